// File: doc/BRIEF.md
# Programmable Down-Counting Timer

This block is a single timer that counts down from a programmed value. Software drives it through a small synchronous register port. The port can set the start and reload value, choose how the count behaves when it reaches zero, read the live count, and manage an interrupt. The count moves only on clock edges where the external `tick_en` input is high and the timer is enabled. A prescaler can thin those qualified edges further, by a factor of 16 or 256.

Three behaviours at zero are available:

- Free-running: the counter wraps to all ones.
- Periodic: the counter reloads from the stored value.
- One-shot: the counter parks at zero until software writes a new start value.

Software chooses at run time whether the counter is 32 or 16 bits wide. There are two ways to change the stored value. A direct write restarts the count at once. A deferred write only changes what the next periodic reload uses. Each arrival at zero latches an interrupt status, and a mask bit gates that status onto the interrupt pin.

Top module: `tmr_unit`

## Requirements
- R1: After reset the register reads are as follows. CTRL reads 0x00000002: disabled, 32-bit, prescale by 1, free-running. VALUE reads 0xFFFFFFFF. LOAD reads 0. RIS reads 0. MASK reads 1. The `irq` pin is low.
- R2: The count changes only on a clock edge where both the CTRL enable bit (bit 0) and `tick_en` are high. While the timer is disabled, the count holds its value.
- R3: CTRL bits 3:2 select the prescale factor: 0 divides by 1, 1 divides by 16, and 2 or 3 divide by 256. The counter then steps on every 1st, 16th or 256th qualified edge. The prescaler restarts from zero while the timer is disabled and on a LOAD write.
- R4: CTRL bit 1 selects the width: 1 gives 32 bits, 0 gives 16 bits. In 16-bit mode only the low 16 bits count and wrap. VALUE then reads those 16 bits zero-extended.
- R5: In free-running mode (CTRL bits 5:4 = 0), a step from zero wraps the count to all ones of the selected width.
- R6: In periodic mode (CTRL bits 5:4 = 1), a step from zero reloads the count from the stored load value.
- R7: In one-shot mode (CTRL bits 5:4 = 2 or 3), the count stops at zero. Further steps have no effect until a LOAD write.
- R8: A LOAD write sets both the count and the stored load value in the same edge. It takes priority over a decrement or zero event on that edge.
- R9: A BGLOAD write changes only the stored load value and leaves the running count alone. The new value is first used at the next periodic reload.
- R10: The raw interrupt status sets on a step that takes the count from 1 to 0. A write of any data to INTCLR clears the status. If a set and a clear fall on the same edge, the set wins.
- R11: `irq` equals the raw status ANDed with MASK bit 0. RIS reads the raw status in bit 0, and MIS reads the masked status in bit 0.
- R12: The register addresses are: 0 LOAD, 1 VALUE (read-only), 2 CTRL, 3 INTCLR (write-only, reads 0), 4 MASK, 5 RIS, 6 MIS, 7 BGLOAD (reads the stored load value). Read data appears on `rdata` one edge after `rd_en` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| tick_en | input | 1 | External count enable |
| irq | output | 1 | Masked interrupt |

## Verification
The in-RTL assertions check the following on every cycle:

- a prescaler step only happens on a qualified edge;
- the count is still whenever no step or load occurs;
- a load write takes effect on the next edge;
- a background write leaves the count alone;
- a periodic reload copies the stored value;
- a one-shot counter at zero stays there;
- set wins over clear in the interrupt status.

The bench covers what only complete scenarios can show:

- the arithmetic of the count across many ticks;
- wrap values in both widths;
- the effective tick rate under each prescale factor and a gated `tick_en`;
- the delayed effect of a background write;
- the read-side view of the status and mask.

// File: rtl/tmr_pkg.sv
// Package: shared types and register addresses for the down-counting timer.
// Assumes a 3-bit register address space and a 6-bit control field.
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_FREE     = 2'd0,
        MODE_PERIODIC = 2'd1,
        MODE_ONESHOT  = 2'd2,
        MODE_ONESHOT2 = 2'd3
    } tmr_mode_e;

    typedef struct packed {
        tmr_mode_e  mode;   // bits 5:4
        logic [1:0] presc;  // bits 3:2
        logic       wide;   // bit 1
        logic       en;     // bit 0
    } tmr_ctrl_t;

    localparam int CTRL_W = $bits(tmr_ctrl_t);

    localparam logic [2:0] A_LOAD   = 3'd0;
    localparam logic [2:0] A_VALUE  = 3'd1;
    localparam logic [2:0] A_CTRL   = 3'd2;
    localparam logic [2:0] A_INTCLR = 3'd3;
    localparam logic [2:0] A_MASK   = 3'd4;
    localparam logic [2:0] A_RIS    = 3'd5;
    localparam logic [2:0] A_MIS    = 3'd6;
    localparam logic [2:0] A_BGLOAD = 3'd7;

endpackage

// File: rtl/tmr_prescaler.sv
// Module: tmr_prescaler
// Turns qualified edges (run && tick_en) into counter steps at a rate of
// 1, 1/2**MID_LOG2 or 1/2**PRE_W. The divider restarts whenever the timer
// is stopped or restart is pulsed. Assumes MID_LOG2 < PRE_W.
module tmr_prescaler #(
    parameter int PRE_W    = 8,
    parameter int MID_LOG2 = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       tick_en,
    input  logic       restart,
    input  logic [1:0] sel,
    output logic       tick
);
    logic [PRE_W-1:0] pcnt;
    logic             qual;

    assign qual = run && tick_en;

    // Divider count: advances on qualified edges, cleared when idle or restarted.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            pcnt <= '0;
        end else if (tick_en) begin
            pcnt <= pcnt + 1'b1;
        end
    end

    // Step selection: pass through, or fire on the last edge of the divide window.
    always_comb begin
        unique case (sel)
            2'd0:    tick = qual;
            2'd1:    tick = qual && (pcnt[MID_LOG2-1:0] == {MID_LOG2{1'b1}});
            default: tick = qual && (pcnt == {PRE_W{1'b1}});
        endcase
    end

    // R2: no step without a qualified edge
    a_r2_tick_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (run && tick_en));

    // R3: a stopped or restarted divider starts from zero on the next edge
    a_r3_divider_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (!run || restart) |=> (pcnt == '0));

endmodule

// File: rtl/tmr_counter.sv
// Module: tmr_counter
// Down counter with a stored load value. The effective width is CNT_W or
// NARROW_W, chosen at run time. Zero handling follows the mode: wrap,
// reload or park. A load write overrides a same-edge step.
// Assumes load_wr and bg_wr are never high together.
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int NARROW_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wide,
    input  tmr_mode_e        mode,
    input  logic             load_wr,
    input  logic             bg_wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] value,
    output logic [CNT_W-1:0] load_val,
    output logic             zero_evt
);
    localparam int HI_W = CNT_W - NARROW_W;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] nxt;

    // Effective count: upper bits hidden in narrow mode.
    assign value = wide ? cnt : {{HI_W{1'b0}}, cnt[NARROW_W-1:0]};

    // Next-count selection and zero detection.
    always_comb begin
        nxt      = cnt;
        zero_evt = 1'b0;
        if (load_wr) begin
            nxt = wdata;
        end else if (tick) begin
            if (value == '0) begin
                unique case (mode)
                    MODE_FREE:     nxt = wide ? {CNT_W{1'b1}}
                                              : {{HI_W{1'b0}}, {NARROW_W{1'b1}}};
                    MODE_PERIODIC: nxt = load_val;
                    default:       nxt = cnt;
                endcase
            end else begin
                nxt      = value - 1'b1;
                zero_evt = (value == {{(CNT_W-1){1'b0}}, 1'b1});
            end
        end
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= {CNT_W{1'b1}};
        else        cnt <= nxt;
    end

    // Stored load value: updated by either load path.
    always_ff @(posedge clk) begin
        if (!rst_n)                load_val <= '0;
        else if (load_wr || bg_wr) load_val <= wdata;
    end

    // R2: no step and no load leaves the count untouched
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_wr) |=> $stable(cnt));

    // R8: a load write lands on the next edge regardless of a step
    a_r8_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |=> (cnt == $past(wdata)));

    // R9: a background write does not disturb the running count
    a_r9_bg_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (bg_wr && !tick) |=> $stable(cnt));

    // R6: a periodic step from zero copies the stored value
    a_r6_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_wr && mode == MODE_PERIODIC && value == '0)
            |=> (cnt == $past(load_val)));

    // R7: a one-shot counter parked at zero stays parked
    a_r7_oneshot_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_wr && (mode == MODE_ONESHOT || mode == MODE_ONESHOT2)
         && value == '0) |=> $stable(cnt));

endmodule

// File: rtl/tmr_irq.sv
// Module: tmr_irq
// Raw interrupt latch with mask gating. Set has priority over clear.
// Assumes set and clr are single-cycle strobes from the same clock domain.
module tmr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic mask,
    output logic raw,
    output logic irq
);
    // Raw status latch.
    always_ff @(posedge clk) begin
        if (!rst_n)   raw <= 1'b0;
        else if (set) raw <= 1'b1;
        else if (clr) raw <= 1'b0;
    end

    assign irq = raw && mask;

    // R10: a set is never lost, even against a same-edge clear
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> raw);

    // R10: a clear without a set empties the status
    a_r10_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !raw);

    // R10: the status only rises because of a zero event
    a_r10_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw) |-> $past(set));

endmodule

// File: rtl/tmr_unit.sv
// Module: tmr_unit (top)
// Register-programmed down-counting timer. It decodes register writes into
// control, mask and load strobes, and returns reads one edge after rd_en.
// Assumes a single-cycle write strobe and at most one address per cycle.
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int NARROW_W = 16,
    parameter int PRE_W    = 8,
    parameter int MID_LOG2 = 4,
    parameter int ADDR_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    input  logic              tick_en,
    output logic              irq
);
    localparam tmr_ctrl_t CTRL_RST = '{mode: MODE_FREE, presc: 2'd0, wide: 1'b1, en: 1'b0};

    tmr_ctrl_t        ctrl;
    logic             mask_q;
    logic             ld_wr, bg_wr, ctrl_wr, clr_wr, mask_wr;
    logic             tick, zero_evt, raw;
    logic [CNT_W-1:0] value, load_val, rd_mux;

    // Write strobes per register.
    always_comb begin
        ld_wr   = wr_en && (addr == A_LOAD);
        ctrl_wr = wr_en && (addr == A_CTRL);
        clr_wr  = wr_en && (addr == A_INTCLR);
        mask_wr = wr_en && (addr == A_MASK);
        bg_wr   = wr_en && (addr == A_BGLOAD);
    end

    // Control and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl   <= CTRL_RST;
            mask_q <= 1'b1;
        end else begin
            if (ctrl_wr) ctrl   <= tmr_ctrl_t'(wdata[CTRL_W-1:0]);
            if (mask_wr) mask_q <= wdata[0];
        end
    end

    tmr_prescaler #(
        .PRE_W   (PRE_W),
        .MID_LOG2(MID_LOG2)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (ctrl.en),
        .tick_en(tick_en),
        .restart(ld_wr),
        .sel    (ctrl.presc),
        .tick   (tick)
    );

    tmr_counter #(
        .CNT_W   (CNT_W),
        .NARROW_W(NARROW_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .wide    (ctrl.wide),
        .mode    (ctrl.mode),
        .load_wr (ld_wr),
        .bg_wr   (bg_wr),
        .wdata   (wdata),
        .value   (value),
        .load_val(load_val),
        .zero_evt(zero_evt)
    );

    tmr_irq u_irq (
        .clk (clk),
        .rst_n(rst_n),
        .set (zero_evt),
        .clr (clr_wr),
        .mask(mask_q),
        .raw (raw),
        .irq (irq)
    );

    // Read selection by address.
    always_comb begin
        unique case (addr)
            A_LOAD, A_BGLOAD: rd_mux = load_val;
            A_VALUE:          rd_mux = value;
            A_CTRL:           rd_mux = {{(CNT_W-CTRL_W){1'b0}}, ctrl};
            A_MASK:           rd_mux = {{(CNT_W-1){1'b0}}, mask_q};
            A_RIS:            rd_mux = {{(CNT_W-1){1'b0}}, raw};
            A_MIS:            rd_mux = {{(CNT_W-1){1'b0}}, irq};
            default:          rd_mux = '0;
        endcase
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    // R4: in narrow mode the visible count never exceeds the narrow range
    a_r4_narrow_range: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.wide && !ctrl_wr) |=> (!ctrl.wide -> value[CNT_W-1:NARROW_W] == '0));

    // R11: the pin is never active while the mask register is clear
    a_r11_mask_gates: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && !wdata[0]) |=> !irq);

endmodule

// File: tb/tmr_unit_tb.sv
module tmr_unit_tb;
    localparam logic [2:0] A_LOAD = 3'd0, A_VALUE = 3'd1, A_CTRL = 3'd2, A_INTCLR = 3'd3,
                           A_MASK = 3'd4, A_RIS = 3'd5, A_MIS = 3'd6, A_BGLOAD = 3'd7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tick_en = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tmr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick_en(tick_en), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write commits at the next posedge.
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    // Enable for exactly m stepping edges. Returns the number of edges with tick_en high.
    task automatic run(input logic [31:0] cfg, input int m, input bit gated, output int q);
        q = 0;
        wr(A_CTRL, cfg | 32'h1);
        for (int i = 0; i < m - 1; i++) begin
            tick_en = gated ? (i % 3 == 0) : 1'b1;
            if (tick_en) q++;
            @(negedge clk);
        end
        tick_en = gated ? ((m - 1) % 3 == 0) : 1'b1;
        if (tick_en) q++;
        wr(A_CTRL, cfg & ~32'h1);
        tick_en = 1'b1;
    endtask

    function automatic logic [31:0] exp_value(input int mode, input bit wide,
                                              input logic [31:0] ld, input longint t);
        longint m, n;
        m = wide ? 64'h1_0000_0000 : 64'h1_0000;
        n = wide ? longint'(ld) : longint'(ld[15:0]);
        if (mode == 0)      return 32'(((n - t) % m + m) % m);
        else if (mode == 1) return (n == 0) ? 32'h0 : 32'(n - (t % (n + 1)));
        else                return (t >= n) ? 32'h0 : 32'(n - t);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int q;
        int nl[3];
        int ml[3];
        nl = '{0, 5, 37};
        ml = '{3, 40, 300};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R12 address map
        rd(A_CTRL, d);  check("R1 ctrl", d, 32'h2);
        rd(A_VALUE, d); check("R1 value", d, 32'hFFFF_FFFF);
        rd(A_LOAD, d);  check("R1 load", d, 32'h0);
        rd(A_RIS, d);   check("R1 ris", d, 32'h0);
        rd(A_MASK, d);  check("R1 mask", d, 32'h1);
        check("R1 irq", {31'b0, irq}, 32'h0);
        rd(A_INTCLR, d); check("R12 intclr reads zero", d, 32'h0);

        // R2 disabled counter holds
        tick_en = 1'b1;
        repeat (20) @(negedge clk);
        rd(A_VALUE, d); check("R2 disabled hold", d, 32'hFFFF_FFFF);

        // Sweep covering R3 R4 R5 R6 R7 R10 R11
        for (int mi = 0; mi < 3; mi++)
            for (int wi = 0; wi < 2; wi++)
                for (int pi = 0; pi < 3; pi++)
                    for (int ni = 0; ni < 3; ni++)
                        for (int mk = 0; mk < 3; mk++) begin
                            logic [31:0] cfg, ldw, ev;
                            longint t;
                            bit ei;
                            cfg = (32'(mi) << 4) | (32'(pi) << 2) | (32'(wi) << 1);
                            ldw = wi ? 32'(nl[ni]) : (32'hABCD_0000 | 32'(nl[ni]));
                            wr(A_CTRL, cfg);
                            wr(A_INTCLR, 32'h0);
                            wr(A_LOAD, ldw);
                            run(cfg, ml[mk], mk == 1, q);
                            t = (pi == 0) ? q : (pi == 1) ? q / 16 : q / 256;
                            ev = exp_value(mi, wi, ldw, t);
                            ei = (nl[ni] > 0) && (t >= nl[ni]);
                            rd(A_VALUE, d);
                            check(mi == 0 ? "R5 R3 R4 free value" : mi == 1 ? "R6 R3 R4 periodic value"
                                                                  : "R7 R3 R4 oneshot value", d, ev);
                            rd(A_RIS, d); check("R10 raw status", d, {31'b0, ei});
                            rd(A_MIS, d); check("R11 masked status", d, {31'b0, ei});
                            check("R11 irq pin", {31'b0, irq}, {31'b0, ei});
                        end

        // R8 load while running restarts at once (periodic, div 1)
        wr(A_CTRL, 32'h10);
        wr(A_LOAD, 32'd10);
        wr(A_CTRL, 32'h11);
        repeat (3) @(negedge clk);
        wr(A_LOAD, 32'd100);
        repeat (4) @(negedge clk);
        wr(A_CTRL, 32'h10);
        rd(A_VALUE, d); check("R8 restart from new load", d, 32'd95);
        rd(A_LOAD, d);  check("R8 load value stored", d, 32'd100);

        // R9 background load: no immediate effect, used at next reload
        wr(A_LOAD, 32'd4);
        wr(A_CTRL, 32'h11);
        wr(A_BGLOAD, 32'd9);
        wr(A_CTRL, 32'h10);
        rd(A_VALUE, d);  check("R9 count untouched", d, 32'd2);
        rd(A_BGLOAD, d); check("R9 stored value", d, 32'd9);
        wr(A_CTRL, 32'h11);
        repeat (5) @(negedge clk);
        wr(A_CTRL, 32'h10);
        rd(A_VALUE, d);  check("R9 reload from new value", d, 32'd6);

        // R10 set wins over a same-edge clear
        wr(A_INTCLR, 32'h0);
        wr(A_LOAD, 32'd1);
        wr(A_CTRL, 32'h11);
        repeat (2) @(negedge clk);
        wr(A_INTCLR, 32'h5A);
        wr(A_CTRL, 32'h10);
        rd(A_RIS, d); check("R10 set beats clear", d, 32'h1);
        wr(A_INTCLR, 32'h0);
        rd(A_RIS, d); check("R10 clear", d, 32'h0);

        // R8 load wins over a same-edge zero event
        wr(A_LOAD, 32'd1);
        wr(A_CTRL, 32'h11);
        wr(A_LOAD, 32'd7);
        wr(A_CTRL, 32'h10);
        rd(A_VALUE, d); check("R8 load beats zero", d, 32'd6);
        rd(A_RIS, d);   check("R8 no interrupt on overridden zero", d, 32'h0);

        // R11 mask gates the pin but not the raw status
        wr(A_LOAD, 32'd2);
        wr(A_CTRL, 32'h11);
        @(negedge clk);
        wr(A_CTRL, 32'h10);
        wr(A_MASK, 32'h0);
        check("R11 pin masked", {31'b0, irq}, 32'h0);
        rd(A_RIS, d); check("R11 raw kept", d, 32'h1);
        rd(A_MIS, d); check("R11 masked read", d, 32'h0);
        wr(A_MASK, 32'h1);
        check("R11 pin unmasked", {31'b0, irq}, 32'h1);

        // R12 read data holds between reads
        rd(A_LOAD, d);
        repeat (3) @(negedge clk);
        check("R12 rdata held", rdata, 32'd2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule